// File: doc/BRIEF.md
# Look-Ahead Rotation Oscillator

This block generates a cosine and sine pair from a signed phase accumulator. The pair is produced by an iterative shift-add rotation engine (CORDIC) that lives inside the block. Each accepted sample-enable advances the accumulator by a phase step. Feedback corrections are added at the same time when they are pending. All angles are signed fixed-point radians with 30 fractional bits. The new phase is computed combinationally in the same cycle, so the rotation of that sample starts from the phase it stands for. A version that started from the stored value would trail by one step.

Before the engine starts, the new phase is brought into (−π, π]. It is then folded into (−π/2, π/2], where the rotation converges. A sign flag that travels with the computation negates both results when the phase was folded by π. A caller loads corrections through a write strobe into holding registers. One pending pair of corrections is consumed on the next accepted enable, and the holding registers are then empty again. The engine is loaded with the inverse of its own gain, so the results have unit amplitude. They come out as 16-bit values with 14 fractional bits.

Top module: `nco_lookahead`

## Requirements
- R1: A synchronous active-high reset clears the accumulator, the held corrections, the outputs (cos_o = sin_o = 0) and valid_o. The first enable after reset with a zero step yields cos ≈ 16384 and sin ≈ 0.
- R2: The result of an accepted enable is cos/sin of the updated phase (old phase + step + any pending corrections), not of the phase before the update.
- R3: Over consecutive accepted enables, the phase is the running sum of all steps.
- R4: The stored phase always lies in (−π, π]. Outputs remain correct when the running sum passes ±π.
- R5: Phases in (π/2, π] and (−π, −π/2] are folded by π before rotation and give correctly signed cosine and sine.
- R6: A strobe on adj_wr_i captures fadj_i and padj_i. Their sum is added once, on the next accepted enable, and is not added again later.
- R7: A strobe on adj_wr_i in the same cycle as an accepted enable is not used by that enable. It is held for the following accepted enable.
- R8: An enable that arrives while a rotation is in progress is ignored. It does not move the phase and does not produce a valid pulse.
- R9: valid_o is a one-cycle pulse. It is high in the 19th cycle after the cycle in which the accepted enable was high (ITER+3 with ITER = 16).
- R10: Output amplitude is unity in Q1.14: cos² + sin² is within 0.2 % of 16384².
- R11: cos_o and sin_o keep their values in every cycle in which valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Sample enable; accepted when no rotation is in progress |
| inc_i | input | 33 | Signed phase step, radians with 30 fractional bits |
| fadj_i | input | 33 | Signed frequency correction, captured on adj_wr_i |
| padj_i | input | 33 | Signed phase correction, captured on adj_wr_i |
| adj_wr_i | input | 1 | Write strobe for the correction holding registers |
| cos_o | output | 16 | Cosine, signed Q1.14 |
| sin_o | output | 16 | Sine, signed Q1.14 |
| valid_o | output | 1 | One-cycle strobe marking new cos_o/sin_o |

## Verification
The bench first checks that the opening result after reset already contains the first step. A design that starts the rotation from the stored phase would show cos(0) there and trail by one step ever after. It then runs step sequences that cross ±π many times and land in every quadrant. A missing wrap would drift out of the engine's range, and a lost sign flag would mirror the outputs. The corrections are written both in an idle cycle and in the same cycle as an enable, which catches double application and premature use. A second enable is issued mid-rotation to confirm that it neither advances the phase nor adds a valid pulse.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int ACC_W = 64;
  localparam int FRAC  = 30;

  typedef logic signed [ACC_W-1:0] acc_t;

  localparam acc_t PI_Q      = 64'sd3373259426;
  localparam acc_t HALF_PI_Q = 64'sd1686629713;
  localparam acc_t TWO_PI_Q  = 64'sd6746518852;
  localparam acc_t KINV_Q    = 64'sd652032874;

  typedef struct packed {
    acc_t ang;
    logic neg;
  } fold_t;

  // arctangent of 2^-i, radians with FRAC fractional bits
  function automatic acc_t atan_q(input int i);
    case (i)
      0:  return 64'sd843314857;
      1:  return 64'sd497837829;
      2:  return 64'sd263043837;
      3:  return 64'sd133525159;
      4:  return 64'sd67021687;
      5:  return 64'sd33543516;
      6:  return 64'sd16775851;
      7:  return 64'sd8388437;
      8:  return 64'sd4194283;
      9:  return 64'sd2097149;
      default: return (i <= FRAC) ? (acc_t'(1) <<< (FRAC - i)) : acc_t'(0);
    endcase
  endfunction

  // bring an angle into (-pi, pi]; inputs stay within a few turns
  function automatic acc_t wrap_pi(input acc_t v);
    acc_t r;
    r = v;
    for (int k = 0; k < 4; k++) begin
      if (r > PI_Q) r = r - TWO_PI_Q;
      else if (r <= -PI_Q) r = r + TWO_PI_Q;
    end
    return r;
  endfunction

  // fold (-pi, pi] into (-pi/2, pi/2], flagging a shift by pi
  function automatic fold_t fold_half(input acc_t w);
    fold_t f;
    if (w > HALF_PI_Q) begin
      f.ang = w - PI_Q;
      f.neg = 1'b1;
    end else if (w <= -HALF_PI_Q) begin
      f.ang = w + PI_Q;
      f.neg = 1'b1;
    end else begin
      f.ang = w;
      f.neg = 1'b0;
    end
    return f;
  endfunction
endpackage

// File: rtl/nco_phase_unit.sv
module nco_phase_unit
  import nco_pkg::*;
#(
  parameter int ANG_W = 33
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en_i,
  input  logic                    busy_i,
  input  logic signed [ANG_W-1:0] inc_i,
  input  logic signed [ANG_W-1:0] fadj_i,
  input  logic signed [ANG_W-1:0] padj_i,
  input  logic                    adj_wr_i,
  output logic                    accept_o,
  output acc_t                    fold_ang_o,
  output logic                    fold_neg_o,
  output acc_t                    acc_o,
  output logic                    pend_o
);
  acc_t  acc_q, fhold_q, phold_q;
  logic  pend_q;
  acc_t  sum_w, next_w;
  fold_t fold_w;

  assign accept_o = en_i & ~busy_i;

  always_comb begin
    sum_w = acc_q + acc_t'(inc_i);
    if (pend_q) sum_w = sum_w + fhold_q + phold_q;
    next_w = wrap_pi(sum_w);
    fold_w = fold_half(next_w);
  end

  assign fold_ang_o = fold_w.ang;
  assign fold_neg_o = fold_w.neg;
  assign acc_o      = acc_q;
  assign pend_o     = pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      fhold_q <= '0;
      phold_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (accept_o) begin
        acc_q <= next_w;
        if (pend_q) begin
          pend_q  <= 1'b0;
          fhold_q <= '0;
          phold_q <= '0;
        end
      end
      // a fresh write wins over consumption: it is kept for the next enable
      if (adj_wr_i) begin
        fhold_q <= acc_t'(fadj_i);
        phold_q <= acc_t'(padj_i);
        pend_q  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/nco_cordic_iter.sv
module nco_cordic_iter
  import nco_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int ITER  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start_i,
  input  logic signed [WIDTH-1:0] z_i,
  input  logic                    neg_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic signed [WIDTH-1:0] x_o,
  output logic signed [WIDTH-1:0] y_o,
  output logic                    neg_o
);
  localparam int CW = $clog2(ITER + 1);

  logic signed [WIDTH-1:0] x_q, y_q, z_q;
  logic signed [WIDTH-1:0] xn_w, yn_w, zn_w;
  logic [CW-1:0]           cnt_q;
  logic                    busy_q, done_q, neg_q;

  function automatic logic signed [3*WIDTH-1:0] rot_step(
    input logic signed [WIDTH-1:0] x, input logic signed [WIDTH-1:0] y,
    input logic signed [WIDTH-1:0] z, input int i);
    logic signed [WIDTH-1:0] xs, ys, at, xn, yn, zn;
    xs = x >>> i;
    ys = y >>> i;
    at = WIDTH'(atan_q(i));
    if (z >= 0) begin
      xn = x - ys;
      yn = y + xs;
      zn = z - at;
    end else begin
      xn = x + ys;
      yn = y - xs;
      zn = z + at;
    end
    return {xn, yn, zn};
  endfunction

  assign {xn_w, yn_w, zn_w} = rot_step(x_q, y_q, z_q, int'(cnt_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q    <= '0;
      y_q    <= '0;
      z_q    <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      neg_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        x_q    <= WIDTH'(KINV_Q);
        y_q    <= '0;
        z_q    <= z_i;
        neg_q  <= neg_i;
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        x_q   <= xn_w;
        y_q   <= yn_w;
        z_q   <= zn_w;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(ITER - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign x_o    = x_q;
  assign y_o    = y_q;
  assign neg_o  = neg_q;
endmodule

// File: rtl/nco_out_stage.sv
module nco_out_stage #(
  parameter int WIDTH = 32,
  parameter int OUT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    done_i,
  input  logic                    neg_i,
  input  logic signed [WIDTH-1:0] x_i,
  input  logic signed [WIDTH-1:0] y_i,
  output logic signed [OUT_W-1:0] cos_o,
  output logic signed [OUT_W-1:0] sin_o,
  output logic                    valid_o
);
  localparam int SHIFT = WIDTH - OUT_W;

  logic signed [WIDTH-1:0] sx_q, sy_q;
  logic                    sv_q;

  function automatic logic signed [OUT_W-1:0] narrow(input logic signed [WIDTH-1:0] v);
    logic signed [WIDTH-1:0] s;
    s = v >>> SHIFT;
    return s[OUT_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      sx_q    <= '0;
      sy_q    <= '0;
      sv_q    <= 1'b0;
      cos_o   <= '0;
      sin_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      sv_q    <= done_i;
      valid_o <= sv_q;
      if (done_i) begin
        sx_q <= neg_i ? -x_i : x_i;
        sy_q <= neg_i ? -y_i : y_i;
      end
      if (sv_q) begin
        cos_o <= narrow(sx_q);
        sin_o <= narrow(sy_q);
      end
    end
  end
endmodule

// File: rtl/nco_lookahead.sv
module nco_lookahead
  import nco_pkg::*;
#(
  parameter int ANG_W = 33,
  parameter int WIDTH = 32,
  parameter int ITER  = 16,
  parameter int OUT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en_i,
  input  logic signed [ANG_W-1:0] inc_i,
  input  logic signed [ANG_W-1:0] fadj_i,
  input  logic signed [ANG_W-1:0] padj_i,
  input  logic                    adj_wr_i,
  output logic signed [OUT_W-1:0] cos_o,
  output logic signed [OUT_W-1:0] sin_o,
  output logic                    valid_o
);
  logic                    accept_w, busy_w, pend_w, fold_neg_w;
  logic                    done_w, neg_w;
  acc_t                    acc_w, fold_w;
  logic signed [WIDTH-1:0] x_w, y_w;

  nco_phase_unit #(.ANG_W(ANG_W)) u_phase (
    .clk(clk), .rst(rst), .en_i(en_i), .busy_i(busy_w),
    .inc_i(inc_i), .fadj_i(fadj_i), .padj_i(padj_i), .adj_wr_i(adj_wr_i),
    .accept_o(accept_w), .fold_ang_o(fold_w), .fold_neg_o(fold_neg_w),
    .acc_o(acc_w), .pend_o(pend_w)
  );

  nco_cordic_iter #(.WIDTH(WIDTH), .ITER(ITER)) u_cordic (
    .clk(clk), .rst(rst), .start_i(accept_w), .z_i(WIDTH'(fold_w)),
    .neg_i(fold_neg_w), .busy_o(busy_w), .done_o(done_w),
    .x_o(x_w), .y_o(y_w), .neg_o(neg_w)
  );

  nco_out_stage #(.WIDTH(WIDTH), .OUT_W(OUT_W)) u_out (
    .clk(clk), .rst(rst), .done_i(done_w), .neg_i(neg_w),
    .x_i(x_w), .y_i(y_w), .cos_o(cos_o), .sin_o(sin_o), .valid_o(valid_o)
  );
endmodule

// File: rtl/nco_lookahead_chk.sv
module nco_lookahead_chk
  import nco_pkg::*;
#(
  parameter int OUT_W = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    en_i,
  input logic                    adj_wr_i,
  input logic                    accept_w,
  input logic                    busy_w,
  input logic                    pend_w,
  input acc_t                    acc_w,
  input acc_t                    fold_w,
  input logic signed [OUT_W-1:0] cos_o,
  input logic signed [OUT_W-1:0] sin_o,
  input logic                    valid_o
);
  localparam longint UNIT2 = 64'sd268435456;
  localparam longint TOL2  = 64'sd537000;

  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (rst)
    accept_w |=> busy_w);

  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (rst)
    (en_i && busy_w) |=> $stable(acc_w));

  p_wrap_range_r4: assert property (@(posedge clk) disable iff (rst)
    (acc_w > -PI_Q) && (acc_w <= PI_Q));

  p_fold_range_r5: assert property (@(posedge clk) disable iff (rst)
    accept_w |-> ((fold_w > -HALF_PI_Q) && (fold_w <= HALF_PI_Q)));

  p_adj_consumed_r6: assert property (@(posedge clk) disable iff (rst)
    (accept_w && !adj_wr_i) |=> !pend_w);

  p_adj_held_r7: assert property (@(posedge clk) disable iff (rst)
    adj_wr_i |=> pend_w);

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> ($stable(cos_o) && $stable(sin_o)));

  p_unit_amp_r10: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> ((longint'(cos_o) * longint'(cos_o) + longint'(sin_o) * longint'(sin_o) > UNIT2 - TOL2) &&
                 (longint'(cos_o) * longint'(cos_o) + longint'(sin_o) * longint'(sin_o) < UNIT2 + TOL2)));
endmodule

bind nco_lookahead nco_lookahead_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .en_i(en_i), .adj_wr_i(adj_wr_i),
  .accept_w(accept_w), .busy_w(busy_w), .pend_w(pend_w),
  .acc_w(acc_w), .fold_w(fold_w),
  .cos_o(cos_o), .sin_o(sin_o), .valid_o(valid_o)
);

// File: tb/nco_lookahead_tb.sv
module nco_lookahead_tb;
  localparam int    LAT  = 19;
  localparam int    TOL  = 4;
  localparam real   SCL  = 1073741824.0;
  localparam int    NV   = 12;
  localparam real   STEP [NV] = '{0.30, 0.70, 1.20, 1.65, 2.50, -0.90,
                                  -2.80, 3.00, 3.10, -3.10, 0.05, -1.57};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic adj_wr = 1'b0;
  logic signed [32:0] inc = '0, fadj = '0, padj = '0;
  logic signed [15:0] cos_o, sin_o;
  logic valid_o;

  int  n_chk = 0, n_fail = 0;
  real ph = 0.0;
  bit  pend = 1'b0;
  real pend_v = 0.0;

  always #5 clk = ~clk;

  nco_lookahead u_dut (
    .clk(clk), .rst(rst), .en_i(en), .inc_i(inc), .fadj_i(fadj),
    .padj_i(padj), .adj_wr_i(adj_wr), .cos_o(cos_o), .sin_o(sin_o),
    .valid_o(valid_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint q30(input real v);
    return longint'(v * SCL);
  endfunction

  task automatic check_out(input string req);
    longint ec, es, a2;
    ec = longint'($cos(ph) * 16384.0);
    es = longint'($sin(ph) * 16384.0);
    chk((longint'(cos_o) - ec <= TOL) && (ec - longint'(cos_o) <= TOL), req, longint'(cos_o), ec);
    chk((longint'(sin_o) - es <= TOL) && (es - longint'(sin_o) <= TOL), req, longint'(sin_o), es);
    a2 = longint'(cos_o) * cos_o + longint'(sin_o) * sin_o;
    chk((a2 > 268435456 - 537000) && (a2 < 268435456 + 537000), "R10 amplitude", a2, 268435456);
  endtask

  // one accepted enable; optional correction write in the same cycle
  task automatic sym(input real step, input bit wr_same, input real f, input real p, input string req);
    int cnt;
    longint qi;
    qi = q30(step);
    @(negedge clk);
    en  = 1'b1;
    inc = 33'(qi);
    if (wr_same) begin
      adj_wr = 1'b1;
      fadj = 33'(q30(f));
      padj = 33'(q30(p));
    end
    @(negedge clk);
    en = 1'b0;
    adj_wr = 1'b0;
    // model of the accepted enable
    ph = ph + real'(qi) / SCL + (pend ? pend_v : 0.0);
    pend = 1'b0;
    if (wr_same) begin
      pend = 1'b1;
      pend_v = real'(q30(f) + q30(p)) / SCL;
    end
    cnt = 1;
    while (!valid_o && cnt < 40) begin
      @(negedge clk);
      cnt++;
    end
    chk(cnt == LAT, "R9 latency", cnt, LAT);
    check_out(req);
    @(negedge clk);
    chk(valid_o == 1'b0, "R9 single pulse", valid_o, 0);
  endtask

  task automatic write_adj(input real f, input real p);
    @(negedge clk);
    adj_wr = 1'b1;
    fadj = 33'(q30(f));
    padj = 33'(q30(p));
    @(negedge clk);
    adj_wr = 1'b0;
    pend = 1'b1;
    pend_v = real'(q30(f) + q30(p)) / SCL;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int nval;
    logic signed [15:0] hc, hs;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(valid_o == 1'b0, "R1 valid in reset", valid_o, 0);
    chk(cos_o == 0 && sin_o == 0, "R1 outputs in reset", cos_o, 0);
    rst = 1'b0;
    // R2 look-ahead: very first result already includes the step
    sym(0.5, 1'b0, 0.0, 0.0, "R2 look-ahead first step");

    // R3 R4 R5 vector walk: running sum, wrap past +-pi, all quadrants
    for (int i = 0; i < NV; i++) sym(STEP[i], 1'b0, 0.0, 0.0, "R3 R4 R5 accumulate");

    // R11 outputs hold between strobes
    hc = cos_o;
    hs = sin_o;
    repeat (6) @(negedge clk);
    chk(cos_o == hc && sin_o == hs, "R11 hold", cos_o, hc);

    // R6 correction applied once
    write_adj(0.2, 0.1);
    sym(0.3, 1'b0, 0.0, 0.0, "R6 correction applied");
    sym(0.3, 1'b0, 0.0, 0.0, "R6 correction not reapplied");

    // R7 write with enable goes to the following enable
    sym(0.4, 1'b1, 0.6, -0.2, "R7 not used same cycle");
    sym(0.1, 1'b0, 0.0, 0.0, "R7 used on next enable");

    // R8 enable during rotation is ignored
    @(negedge clk);
    en = 1'b1;
    inc = 33'(q30(0.4));
    @(negedge clk);
    en = 1'b0;
    ph = ph + real'(q30(0.4)) / SCL;
    nval = 0;
    for (int c = 2; c <= 30; c++) begin
      if (c == 6) begin
        en = 1'b1;
        inc = 33'(q30(1.0));
      end else begin
        en = 1'b0;
      end
      @(negedge clk);
      if (valid_o) begin
        nval++;
        check_out("R8 busy result");
      end
    end
    en = 1'b0;
    chk(nval == 1, "R8 valid count", nval, 1);
    sym(0.2, 1'b0, 0.0, 0.0, "R8 phase not advanced by ignored enable");

    // R1 mid-run reset clears everything
    write_adj(0.5, 0.5);
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(valid_o == 1'b0 && cos_o == 0 && sin_o == 0, "R1 reset clears outputs", cos_o, 0);
    rst = 1'b0;
    ph = 0.0;
    pend = 1'b0;
    sym(0.0, 1'b0, 0.0, 0.0, "R1 zero phase after reset");
    finish_run();
  end
endmodule